// File: doc/BRIEF.md
# Banked External Memory Address Decoder

This block sits on the processor's bus and classifies each bus cycle. It takes a 20-bit logical address, a flag that tells an instruction fetch apart from a data access, and a mode input. From these it drives one region select: the special-function area, internal RAM, reserved space, internal ROM, or one of four external chip-select windows. The upper part of the map is banked, so eight 512 KB pages give a 4 MB external space. For cycles in the banked region, the 3-bit bank number is put on the three upper chip-select lines.

An 8-bit bank register holds the bank used for data accesses and an offset flag. The CPU writes it with a clocked write strobe at a parameterised address and can read it back at any time. The region and bank outputs are combinational. They depend on the current address, the cycle type, the mode and the registered bank value. Instruction fetches in the switchable range always use the last bank, and the top quarter of the map is fixed to the last bank for every cycle type.

Top module: `bank_xmem_decoder`

## Requirements
- R1: After reset the bank register holds zero, so `rdata` reads 8'h00.
- R2: A clock edge with `wr_en` high and `addr` equal to `REG_ADDR` loads `wdata[5:3]` as the bank and `wdata[2]` as the offset flag. `rdata` always reads {2'b00, bank[2:0], offset, 2'b00}, so bits 7, 6, 1 and 0 read 0 even after 1s are written to them.
- R3: A write strobe at any other address leaves the register unchanged, as `rdata` shows.
- R4: Addresses 0x00000–0x003FF select the SFR area. Addresses 0x00400–`RAM_END` select internal RAM. Addresses from `RAM_END`+1 to 0x03FFF select reserved space, and no chip select is asserted for them.
- R5: `cs_sel[3]` covers 0x04000–0x07FFF, `cs_sel[2]` covers 0x08000–0x27FFF and `cs_sel[1]` covers 0x28000–0x3FFFF.
- R6: For every address exactly one of `sel_sfr`, `sel_ram`, `sel_rsvd`, `sel_rom` and `cs_sel[3:0]` is high.
- R7: A data access (`is_fetch`=0) in 0x40000–0xBFFFF uses the bank held in the register.
- R8: An instruction fetch (`is_fetch`=1) in 0x40000–0xBFFFF uses bank 7.
- R9: Any access in 0xC0000–0xFFFFF uses bank 7, whatever the cycle type.
- R10: With `cpu_mode`=0 (memory expansion), addresses from `ROM_START` upward select internal ROM and assert no chip select. With `cpu_mode`=1 (microprocessor), every address from 0x40000 upward asserts `cs_sel[0]`.
- R11: `cs_pins` (bit 2 = CS3, bit 0 = CS1) carries the binary bank number while `cs_sel[0]` is high. Otherwise it carries `cs_sel[3:1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank register |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 20 | Logical bus address of the current cycle |
| is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| cpu_mode | input | 1 | 0 = memory expansion, 1 = microprocessor |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Bank register read value |
| sel_sfr | output | 1 | SFR area selected |
| sel_ram | output | 1 | Internal RAM selected |
| sel_rsvd | output | 1 | Reserved space selected |
| sel_rom | output | 1 | Internal ROM selected |
| cs_sel | output | 4 | One-hot external window strobes, index = chip-select number |
| cs_pins | output | 3 | Upper chip-select lines: bank number or window strobes |

## Verification
Addresses are placed on both sides of every region boundary, including the RAM end and ROM start parameters, so an off-by-one error in any comparison selects the wrong region. The banked range is accessed as a data access and as a fetch, with several register values. A fetch that wrongly takes the register bank, or a data access that wrongly takes bank 7, then shows up on `cs_pins`. The top quarter is accessed in both modes and with both cycle types, which separates the ROM decode from the external decode with bank 7. Register writes use all-ones data, mixed fields and a wrong address, to check field placement, the reserved bits that read as zero and the address match.

// File: rtl/bxd_pkg.sv
package bxd_pkg;
  localparam int AW = 20;
  localparam int BW = 3;

  localparam logic [AW-1:0] SFR_LAST  = 20'h003FF;
  localparam logic [AW-1:0] CS3_FIRST = 20'h04000;
  localparam logic [AW-1:0] CS2_FIRST = 20'h08000;
  localparam logic [AW-1:0] CS1_FIRST = 20'h28000;
  localparam logic [AW-1:0] CS0_FIRST = 20'h40000;
  localparam logic [AW-1:0] PIN_FIRST = 20'hC0000;
  localparam logic [BW-1:0] LAST_BANK = '1;

  typedef enum logic [2:0] {
    RG_SFR, RG_RAM, RG_RSVD, RG_ROM, RG_CS0, RG_CS1, RG_CS2, RG_CS3
  } region_e;

  function automatic region_e classify(input logic [AW-1:0] a,
                                       input logic [AW-1:0] ram_end,
                                       input logic [AW-1:0] rom_start,
                                       input logic mp_mode);
    region_e r;
    if (a <= SFR_LAST)                      r = RG_SFR;
    else if (a <= ram_end)                  r = RG_RAM;
    else if (a < CS3_FIRST)                 r = RG_RSVD;
    else if (a < CS2_FIRST)                 r = RG_CS3;
    else if (a < CS1_FIRST)                 r = RG_CS2;
    else if (a < CS0_FIRST)                 r = RG_CS1;
    else if (!mp_mode && a >= rom_start)    r = RG_ROM;
    else                                    r = RG_CS0;
    return r;
  endfunction

  function automatic logic [BW-1:0] pick_bank(input logic [AW-1:0] a,
                                              input logic fetch,
                                              input logic [BW-1:0] reg_bank);
    if (a >= PIN_FIRST || fetch) return LAST_BANK;
    return reg_bank;
  endfunction
endpackage

// File: rtl/bxd_bank_reg.sv
module bxd_bank_reg
  import bxd_pkg::*;
#(
  parameter logic [AW-1:0] REG_ADDR = 20'h00010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [BW-1:0] bank,
  output logic          ofs,
  output logic          wr_hit
);
  assign wr_hit = wr_en && (addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= '0;
      ofs  <= 1'b0;
    end else if (wr_hit) begin
      bank <= wdata[5:3];
      ofs  <= wdata[2];
    end
  end

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (bank == $past(wdata[5:3])) && (ofs == $past(wdata[2])));

  p_hold_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable({bank, ofs}));
endmodule

// File: rtl/bxd_region_dec.sv
module bxd_region_dec
  import bxd_pkg::*;
#(
  parameter logic [AW-1:0] RAM_END   = 20'h02BFF,
  parameter logic [AW-1:0] ROM_START = 20'hC0000
) (
  input  logic          [AW-1:0] addr,
  input  logic                   mp_mode,
  output region_e                region,
  output logic          [7:0]    hit_vec
);
  localparam int NREG = 8;

  assign region = classify(addr, RAM_END, ROM_START, mp_mode);

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit_vec[i] = (region == region_e'(i));
  end
endmodule

// File: rtl/bxd_bank_sel.sv
module bxd_bank_sel
  import bxd_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          is_fetch,
  input  logic [BW-1:0] reg_bank,
  output logic [BW-1:0] bank_out
);
  assign bank_out = pick_bank(addr, is_fetch, reg_bank);
endmodule

// File: rtl/bank_xmem_decoder.sv
module bank_xmem_decoder
  import bxd_pkg::*;
#(
  parameter logic [19:0] RAM_END   = 20'h02BFF,
  parameter logic [19:0] ROM_START = 20'hC0000,
  parameter logic [19:0] REG_ADDR  = 20'h00010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] addr,
  input  logic        is_fetch,
  input  logic        cpu_mode,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        sel_sfr,
  output logic        sel_ram,
  output logic        sel_rsvd,
  output logic        sel_rom,
  output logic [3:0]  cs_sel,
  output logic [2:0]  cs_pins
);
  logic [BW-1:0] reg_bank;
  logic          reg_ofs;
  logic          wr_hit;
  region_e       region;
  logic [7:0]    hit_vec;
  logic [BW-1:0] eff_bank;
  logic          banked_cycle;

  bxd_bank_reg #(.REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .bank(reg_bank), .ofs(reg_ofs), .wr_hit(wr_hit)
  );

  bxd_region_dec #(.RAM_END(RAM_END), .ROM_START(ROM_START)) u_dec (
    .addr(addr), .mp_mode(cpu_mode), .region(region), .hit_vec(hit_vec)
  );

  bxd_bank_sel u_bank (
    .addr(addr), .is_fetch(is_fetch), .reg_bank(reg_bank), .bank_out(eff_bank)
  );

  assign rdata    = {2'b00, reg_bank, reg_ofs, 2'b00};
  assign sel_sfr  = hit_vec[RG_SFR];
  assign sel_ram  = hit_vec[RG_RAM];
  assign sel_rsvd = hit_vec[RG_RSVD];
  assign sel_rom  = hit_vec[RG_ROM];
  assign cs_sel   = {hit_vec[RG_CS3], hit_vec[RG_CS2], hit_vec[RG_CS1], hit_vec[RG_CS0]};

  assign banked_cycle = (region == RG_CS0);
  assign cs_pins      = banked_cycle ? eff_bank : cs_sel[3:1];

  p_one_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sel_sfr, sel_ram, sel_rsvd, sel_rom, cs_sel}));

  p_data_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel[0] && !is_fetch && addr[19:18] != 2'b11) |-> cs_pins == rdata[5:3]);

  p_fetch_bank7_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel[0] && is_fetch) |-> cs_pins == 3'b111);

  p_top_bank7_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel[0] && addr[19:18] == 2'b11) |-> cs_pins == 3'b111);

  p_rom_only_exp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rom |-> (!cpu_mode && cs_sel == 4'b0000));

  p_pins_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_sel[0] |-> cs_pins == cs_sel[3:1]);
endmodule

// File: tb/test_bank_xmem_decoder.sv
module test_bank_xmem_decoder;
  localparam logic [19:0] T_RAM_END = 20'h02BFF;
  localparam logic [19:0] T_ROM_ST  = 20'hC0000;
  localparam logic [19:0] T_REG     = 20'h00010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic is_fetch = 1'b0, cpu_mode = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic sel_sfr, sel_ram, sel_rsvd, sel_rom;
  logic [3:0] cs_sel;
  logic [2:0] cs_pins;

  always #2.5 clk = ~clk;

  bank_xmem_decoder #(.RAM_END(T_RAM_END), .ROM_START(T_ROM_ST), .REG_ADDR(T_REG)) i_bank_xmem_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .is_fetch(is_fetch), .cpu_mode(cpu_mode),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .sel_sfr(sel_sfr), .sel_ram(sel_ram),
    .sel_rsvd(sel_rsvd), .sel_rom(sel_rom), .cs_sel(cs_sel), .cs_pins(cs_pins)
  );

  typedef struct { logic [7:0] sel; logic [2:0] pins; logic [7:0] rd; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  logic [2:0] m_bank = '0;
  logic m_ofs = 1'b0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // sel vector: {sfr, ram, rsvd, rom, cs3, cs2, cs1, cs0}
  function automatic exp_t model(input logic [19:0] a, input logic f, input logic mp, input string tag);
    exp_t e;
    logic [2:0] bk;
    if (a < 20'h00400)                e.sel = 8'b1000_0000;
    else if (a <= T_RAM_END)          e.sel = 8'b0100_0000;
    else if (a[19:14] == 6'd0)        e.sel = 8'b0010_0000;
    else if (a[19:15] == 5'd0)        e.sel = 8'b0000_1000;
    else if (a < 20'h28000)           e.sel = 8'b0000_0100;
    else if (a[19:18] == 2'b00)       e.sel = 8'b0000_0010;
    else if (mp == 1'b0 && a >= T_ROM_ST) e.sel = 8'b0001_0000;
    else                              e.sel = 8'b0000_0001;
    bk = (a[19:18] == 2'b11 || f) ? 3'd7 : m_bank;
    e.pins = e.sel[0] ? bk : e.sel[3:1];
    e.rd = {2'b00, m_bank, m_ofs, 2'b00};
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [19:0] a, input logic f, input logic mp,
                       input logic we, input logic [7:0] wd, input string tag);
    @(negedge clk);
    addr = a; is_fetch = f; cpu_mode = mp; wr_en = we; wdata = wd;
    q.push_back(model(a, f, mp, tag));
    if (we && a == T_REG) begin
      m_bank = wd[5:3];
      m_ofs  = wd[2];
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " select"}, {8'h00, sel_sfr, sel_ram, sel_rsvd, sel_rom, cs_sel}, {8'h00, e.sel});
        check({e.tag, " pins"}, {13'd0, cs_pins}, {13'd0, e.pins});
        check({e.tag, " rdata"}, {8'h00, rdata}, {8'h00, e.rd});
      end
    end
  end

  initial begin : watchdog
    #(5.0 * 200000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    #7;
    check("R1 reset rdata", {8'h00, rdata}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    drive(20'h00000, 0, 0, 0, 8'h00, "R1 R4 sfr low after reset");
    drive(20'h40000, 0, 1, 0, 8'h00, "R1 R7 reset bank 0");
    // R4 boundaries
    drive(20'h003FF, 0, 0, 0, 8'h00, "R4 sfr top");
    drive(20'h00400, 0, 0, 0, 8'h00, "R4 ram first");
    drive(T_RAM_END, 1, 0, 0, 8'h00, "R4 ram last");
    drive(T_RAM_END + 20'd1, 0, 0, 0, 8'h00, "R4 reserved first");
    drive(20'h03FFF, 0, 1, 0, 8'h00, "R4 reserved last");
    // R5 windows
    drive(20'h04000, 0, 0, 0, 8'h00, "R5 R11 cs3 first");
    drive(20'h07FFF, 1, 0, 0, 8'h00, "R5 cs3 last");
    drive(20'h08000, 0, 0, 0, 8'h00, "R5 cs2 first");
    drive(20'h27FFF, 0, 1, 0, 8'h00, "R5 cs2 last");
    drive(20'h28000, 0, 0, 0, 8'h00, "R5 cs1 first");
    drive(20'h3FFFF, 0, 0, 0, 8'h00, "R5 R11 cs1 last");
    // R2 writes
    drive(T_REG, 0, 0, 1, 8'hFF, "R2 write all ones");
    drive(T_REG, 0, 0, 0, 8'h00, "R2 readback masks reserved bits");
    drive(T_REG, 0, 0, 1, 8'h28, "R2 write bank5");
    drive(20'h40000, 0, 0, 0, 8'h00, "R7 R11 data bank5 low edge");
    drive(20'hBFFFF, 0, 1, 0, 8'h00, "R7 data bank5 high edge");
    drive(20'h40000, 1, 0, 0, 8'h00, "R8 fetch low edge");
    drive(20'hBFFFF, 1, 1, 0, 8'h00, "R8 fetch high edge");
    // R3 miss-address write
    drive(T_REG + 20'd1, 0, 0, 1, 8'h16, "R3 write wrong address");
    drive(20'h50000, 0, 0, 0, 8'h00, "R3 bank unchanged");
    drive(T_REG, 0, 0, 1, 8'h16, "R2 write bank2 offset");
    drive(20'h60000, 0, 0, 0, 8'h00, "R2 R7 data bank2");
    drive(20'h60000, 1, 0, 0, 8'h00, "R8 fetch ignores bank2");
    // R9 / R10 top quarter
    drive(20'hC0000, 0, 1, 0, 8'h00, "R9 R10 mp data top");
    drive(20'hFFFFF, 1, 1, 0, 8'h00, "R9 mp fetch top");
    drive(20'hBFFFF, 0, 0, 0, 8'h00, "R10 exp below rom");
    drive(20'hC0000, 0, 0, 0, 8'h00, "R10 exp rom first");
    drive(20'hFFFFF, 1, 0, 0, 8'h00, "R10 exp rom last");
    drive(T_REG, 0, 0, 1, 8'h00, "R2 clear");
    drive(20'hE0000, 0, 1, 0, 8'h00, "R9 top pinned with bank0");
    drive(20'h00000, 0, 0, 0, 8'h00, "R2 cleared readback");
    @(negedge clk);
    @(negedge clk);
    #3;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule